// File: doc/BRIEF.md
# Three-Resolution One-Shot Countdown Timer

This block is a timer on the peripheral bus of a small 8-bit processor. It counts down once and then stops. Software writes an 8-bit count to one of three register addresses. The address chosen sets the unit of the count: microseconds, milliseconds or seconds. The same write loads the count and starts the countdown, so there is no separate start command. Software then polls a busy flag until the count has run out.

A prescaler chain is built from a clock-frequency parameter. It produces a one-cycle microsecond tick, and from that a millisecond tick and a second tick. Each tick is derived from the one below it by a programmable ratio. Every start clears the whole prescaler chain, so the first decrement falls exactly one unit after the write. A write that lands while a count is running replaces it outright. The old count and the old resolution are discarded.

Top module: `tri_base_timer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `bus_rdata` reads 8'h00 and no count is running.
- R2: A write to address 0 with a count N > 0 raises busy (`bus_rdata[0]`) after the write edge. Busy stays high for exactly N×U cycles, where U is the number of clock cycles in one microsecond.
- R3: A write to address 1 with N > 0 keeps busy high for exactly N×U×US_PER_MS cycles.
- R4: A write to address 2 with N > 0 keeps busy high for exactly N×U×US_PER_MS×MS_PER_S cycles.
- R5: A write takes effect only when both `bus_sel` and `bus_we` are high. If either is low, busy does not change.
- R6: A write to address 3 is ignored. It neither starts an idle timer nor changes the end time of a running count.
- R7: A write to address 0, 1 or 2 while busy restarts the timer with the new count and resolution, measured from the new write edge. This holds even when the write falls on the edge where the old count would have expired.
- R8: A write of count 0 to address 0, 1 or 2 leaves busy at 0 after the write edge, including when it cancels a running count.
- R9: A read returns the same status at every address. Bit 0 is busy and bits 7 to 1 are 0, so the value is 8'h01 while busy and 8'h00 when done.
- R10: The timer is one-shot. After expiry, busy stays 0 until the next valid write.
- R11: The full count range up to 255 is honoured. A count of 255 at microsecond resolution lasts 255×U cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Peripheral select from the external address decoder |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 2 | Register select: 0 = microseconds, 1 = milliseconds, 2 = seconds, 3 = unused |
| bus_wdata | input | 8 | Count to load |
| bus_rdata | output | 8 | Status: bit 0 = busy, other bits 0 |

## Verification
Two functions can fall in the same cycle: a restarting write, and the selected tick that would have taken the count to zero. When they coincide the write must win, busy must stay high, and the new duration must be timed from that edge. The bench provokes this by issuing a write on the exact edge where a running two-microsecond count expires. It then checks that busy stays up for the full new millisecond duration and falls on the predicted cycle. The same exact-cycle sampling, applied after a mid-unit restart, also shows that the prescaler chain is cleared on every start.

// File: rtl/tbt_pkg.sv
package tbt_pkg;

  // Resolution selected by the register address of a write.
  typedef enum logic [1:0] {
    RES_US   = 2'd0,
    RES_MS   = 2'd1,
    RES_S    = 2'd2,
    RES_NONE = 2'd3
  } res_e;

  localparam int unsigned NUM_STAGES = 3;

endpackage

// File: rtl/tbt_div_stage.sv
// One modulo-DIV stage. It counts advance pulses and emits a tick on the
// pulse that completes a period. clr has priority and restarts the phase.
module tbt_div_stage #(
  parameter int unsigned DIV = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic adv,
  output logic tick
);

  localparam int unsigned W    = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  assign tick = adv && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (adv) begin
      if (cnt_q == LAST) cnt_q <= '0;
      else               cnt_q <= cnt_q + W'(1);
    end
  end

endmodule

// File: rtl/tbt_prescaler.sv
// Chain of division stages: cycles -> us tick -> ms tick -> s tick.
module tbt_prescaler #(
  parameter int unsigned CYC_PER_US = 50,
  parameter int unsigned US_PER_MS  = 1000,
  parameter int unsigned MS_PER_S   = 1000
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            clr,
  input  logic                            run,
  output logic [tbt_pkg::NUM_STAGES-1:0]  ticks
);

  localparam int unsigned N = tbt_pkg::NUM_STAGES;

  logic [N:0] chain;
  assign chain[0] = run;

  for (genvar g = 0; g < N; g++) begin : g_stage
    localparam int unsigned D = (g == 0) ? CYC_PER_US :
                                (g == 1) ? US_PER_MS  : MS_PER_S;
    tbt_div_stage #(.DIV(D)) stage_i (
      .clk  (clk),
      .rst  (rst),
      .clr  (clr),
      .adv  (chain[g]),
      .tick (chain[g+1])
    );
    assign ticks[g] = chain[g+1];
  end

endmodule

// File: rtl/tbt_countdown.sv
// Count register, busy flag and latched resolution.
module tbt_countdown #(
  parameter int unsigned CW = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           start,
  input  logic [CW-1:0]                  load_val,
  input  tbt_pkg::res_e                  load_res,
  input  logic [tbt_pkg::NUM_STAGES-1:0] ticks,
  output logic                           busy,
  output logic [CW-1:0]                  count
);
  import tbt_pkg::*;

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  res_e          res_q;
  logic          step;

  always_comb begin
    unique case (res_q)
      RES_US:  step = ticks[0];
      RES_MS:  step = ticks[1];
      RES_S:   step = ticks[2];
      default: step = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      res_q  <= RES_US;
    end else if (start) begin
      cnt_q  <= load_val;
      busy_q <= (load_val != '0);
      res_q  <= load_res;
    end else if (busy_q && step) begin
      cnt_q <= cnt_q - CW'(1);
      if (cnt_q == CW'(1)) busy_q <= 1'b0;
    end
  end

  assign busy  = busy_q;
  assign count = cnt_q;

endmodule

// File: rtl/tri_base_timer.sv
module tri_base_timer #(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned US_PER_MS = 1000,
  parameter int unsigned MS_PER_S  = 1000,
  parameter int unsigned CW        = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [1:0]    bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [7:0]    bus_rdata
);
  import tbt_pkg::*;

  localparam int unsigned CYC_PER_US = (CLK_HZ / 1_000_000 > 0) ? CLK_HZ / 1_000_000 : 1;

  logic                  start_w;
  logic                  busy_w;
  logic [CW-1:0]         cnt_w;
  logic [NUM_STAGES-1:0] ticks_w;
  res_e                  res_w;

  assign res_w   = res_e'(bus_addr);
  assign start_w = bus_sel && bus_we && (res_w != RES_NONE);

  tbt_prescaler #(
    .CYC_PER_US (CYC_PER_US),
    .US_PER_MS  (US_PER_MS),
    .MS_PER_S   (MS_PER_S)
  ) presc_i (
    .clk   (clk),
    .rst   (rst),
    .clr   (start_w),
    .run   (busy_w),
    .ticks (ticks_w)
  );

  tbt_countdown #(.CW(CW)) cdn_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start_w),
    .load_val (bus_wdata),
    .load_res (res_w),
    .ticks    (ticks_w),
    .busy     (busy_w),
    .count    (cnt_w)
  );

  // Status at every address; busy is a flop output.
  assign bus_rdata = {7'b0, busy_w};

endmodule

// File: rtl/tri_base_timer_chk.sv
module tri_base_timer_chk #(
  parameter int unsigned CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_sel,
  input logic          bus_we,
  input logic [1:0]    bus_addr,
  input logic [CW-1:0] bus_wdata,
  input logic [7:0]    bus_rdata,
  input logic [CW-1:0] count_q,
  input logic [2:0]    ticks
);

  logic wr_ok;
  assign wr_ok = bus_sel && bus_we && (bus_addr != 2'd3);

  // R8
  zero_load_idle_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ok && (bus_wdata == '0) |=> !bus_rdata[0]);

  // R2
  nonzero_load_busy_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ok && (bus_wdata != '0) |=> bus_rdata[0]);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_ok && !bus_rdata[0] |=> !bus_rdata[0]);

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_ok && bus_rdata[0] |=> (count_q == $past(count_q)) ||
                               (count_q == $past(count_q) - CW'(1)));

  // R4
  tick_nest_chk: assert property (@(posedge clk) disable iff (rst)
    ticks[2] |-> ticks[1] && ticks[0]);

  // R9
  busy_count_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[0] |-> (count_q != '0));

endmodule

bind tri_base_timer tri_base_timer_chk #(.CW(CW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .count_q   (cnt_w),
  .ticks     (ticks_w)
);

// File: tb/tri_base_timer_tb_top.sv
`timescale 1ns/1ps
module tri_base_timer_tb_top;

  // 4 cycles per us, 4 us per ms, 3 ms per s.
  localparam int unsigned U_US = 4;
  localparam int unsigned U_MS = U_US * 4;
  localparam int unsigned U_S  = U_MS * 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tri_base_timer #(
    .CLK_HZ    (4_000_000),
    .US_PER_MS (4),
    .MS_PER_S  (3),
    .CW        (8)
  ) dut_i (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  // {addr[29:28], count[27:20], busy duration in cycles[19:0]}
  localparam int NV = 9;
  localparam logic [29:0] VEC [NV] = '{
    {2'd0, 8'd1,   20'(1 * U_US)},
    {2'd0, 8'd7,   20'(7 * U_US)},
    {2'd1, 8'd1,   20'(1 * U_MS)},
    {2'd1, 8'd3,   20'(3 * U_MS)},
    {2'd2, 8'd1,   20'(1 * U_S)},
    {2'd2, 8'd2,   20'(2 * U_S)},
    {2'd0, 8'd255, 20'(255 * U_US)},
    {2'd2, 8'd0,   20'd0},
    {2'd1, 8'd0,   20'd0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Ends one negedge after the write edge (m = 0).
  task automatic do_write(input logic [1:0] a, input logic [7:0] d,
                          input logic s = 1'b1, input logic w = 1'b1);
    @(negedge clk);
    bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    wait_cyc(4);
    // R1: reset state
    check("R1", bus_rdata, 8'h00);
    rst = 1'b0;
    wait_cyc(1);
    check("R1", bus_rdata, 8'h00);

    // Vector table: R2 R3 R4 R8 R11
    for (int i = 0; i < NV; i++) begin
      logic [1:0]  a;
      logic [7:0]  d;
      int          dur;
      string       tag;
      a   = VEC[i][29:28];
      d   = VEC[i][27:20];
      dur = int'(VEC[i][19:0]);
      if (d == 8'd0)        tag = "R8";
      else if (d == 8'd255) tag = "R11";
      else if (a == 2'd0)   tag = "R2";
      else if (a == 2'd1)   tag = "R3";
      else                  tag = "R4";
      do_write(a, d);
      if (dur == 0) begin
        check(tag, bus_rdata, 8'h00);
      end else begin
        check(tag, bus_rdata, 8'h01);
        wait_cyc(dur - 1);
        check(tag, bus_rdata, 8'h01);
        wait_cyc(1);
        check(tag, bus_rdata, 8'h00);
      end
      wait_cyc(3);
    end

    // R5: strobe without select, select without strobe
    do_write(2'd0, 8'd5, 1'b1, 1'b0);
    check("R5", bus_rdata, 8'h00);
    wait_cyc(10);
    check("R5", bus_rdata, 8'h00);
    do_write(2'd0, 8'd5, 1'b0, 1'b1);
    check("R5", bus_rdata, 8'h00);

    // R6: address 3 while idle, then while running
    do_write(2'd3, 8'd9);
    check("R6", bus_rdata, 8'h00);
    do_write(2'd0, 8'd10);            // 40 cycles
    wait_cyc(9);                      // m = 9
    do_write(2'd3, 8'd1);             // m = 11
    wait_cyc(28);                     // m = 39
    check("R6", bus_rdata, 8'h01);
    wait_cyc(1);
    check("R6", bus_rdata, 8'h00);

    // R9: every address reads the status
    do_write(2'd1, 8'd4);
    for (int a = 0; a < 4; a++) begin
      bus_addr = 2'(a);
      bus_sel = 1'b1;
      @(negedge clk);
      check("R9", bus_rdata, 8'h01);
      bus_sel = 1'b0;
    end
    wait_cyc(70);
    bus_addr = 2'd2;
    check("R9", bus_rdata, 8'h00);

    // R7: mid-unit restart with another resolution
    do_write(2'd2, 8'd5);
    wait_cyc(20);
    do_write(2'd0, 8'd2);
    wait_cyc(7);
    check("R7", bus_rdata, 8'h01);
    wait_cyc(1);
    check("R7", bus_rdata, 8'h00);

    // R7: write on the expiry edge wins over expiry
    do_write(2'd0, 8'd2);             // would expire at m = 8
    wait_cyc(6);
    do_write(2'd1, 8'd1);             // write edge is m = 8
    check("R7", bus_rdata, 8'h01);
    wait_cyc(U_MS - 1);
    check("R7", bus_rdata, 8'h01);
    wait_cyc(1);
    check("R7", bus_rdata, 8'h00);

    // R8: zero write cancels a running count
    do_write(2'd1, 8'd5);
    wait_cyc(5);
    do_write(2'd0, 8'd0);
    check("R8", bus_rdata, 8'h00);

    // R10: stays idle after expiry
    wait_cyc(300);
    check("R10", bus_rdata, 8'h00);

    // R1: reset during a count
    do_write(2'd2, 8'd3);
    wait_cyc(5);
    rst = 1'b1;
    wait_cyc(1);
    check("R1", bus_rdata, 8'h00);
    rst = 1'b0;
    wait_cyc(200);
    check("R1", bus_rdata, 8'h00);

    finish_run();
  end

endmodule